// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Interface

This block is the digital front end of a two-channel 10-bit converter. A host writes 16-bit command words over a three-wire serial port made of an active-low select/load strobe, a serial clock and a data line. The serial pins are sampled into the system clock domain, and the word is shifted in most significant bit first on each rising serial clock edge while the strobe is low. When the strobe returns high, the command held in the shift register runs. The top 4 bits of the word are the operation code. The next 10 bits are the data code. The last 2 bits carry no meaning.

Each channel holds an input register and a DAC register. A command can load either input register, or both, without touching the outputs. The DAC registers are only ever written together, by a transfer that copies both input registers at once. Any transfer also brings the block out of sleep. A sleep command drops the per-channel drive enables, which stand in for a high-impedance output, and every register keeps its value. While the block sleeps, new input codes can still be loaded ahead of the next transfer.

Top module: `duo_dac_cmd_if`

## Requirements
- R1: A command word is 16 bits and enters MSB first, one bit per rising serial clock edge while `ser_csn_i` is low. Operation code = word[15:12], data code = word[11:2], and word[1:0] is ignored.
- R2: Serial clock edges that arrive while `ser_csn_i` is high shift nothing into the word.
- R3: The DAC outputs change only when a command executes on the rising edge of `ser_csn_i`. Code 0001 loads input register A and code 0010 loads input register B. Neither code changes the outputs or the enables.
- R4: Code 0000 and the reserved codes 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change no register, output or enable.
- R5: Code 1000 copies both input registers into both DAC registers and enables both outputs.
- R6: Code 1001 loads input A with the data code, and code 1010 loads input B with it. Both then copy both input registers to the DAC registers and enable the outputs.
- R7: Code 1111 loads the data code into both input registers, copies it to both DAC registers, and enables the outputs.
- R8: Code 1101 enables the outputs and leaves all four registers unchanged.
- R9: Code 1110 clears both drive enables, ignores the data code, and keeps every register.
- R10: While asleep, codes 0001 and 0010 load input registers without setting the enables. A later 1101 restores the old DAC codes, and a later 1000 shows the new ones.
- R11: After reset both DAC codes are 0 and both drive enables are 1.
- R12: When more or fewer than 16 clocks arrive in one select window, the command is taken from the last 16 bits shifted in, including bits from earlier windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn_i | input | 1 | Serial select; low enables shifting, rising edge executes |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_din_i | input | 1 | Serial data, sampled on rising serial clock |
| code_a_o | output | DATA_W | DAC register of channel A |
| code_b_o | output | DATA_W | DAC register of channel B |
| drive_en_a_o | output | 1 | Channel A output drive enable (0 = high impedance) |
| drive_en_b_o | output | 1 | Channel B output drive enable (0 = high impedance) |

## Verification
The bench builds the block with its default parameters: a 10-bit data code, 2 don't-care bits and a two-stage input synchroniser. These values fix the 16-bit word, so hand-built words and partial windows land on known bit positions. Each serial clock phase spans three system clocks, which is slow enough for the synchroniser to resolve every edge. With these settings the bench can place a 12-bit window that borrows its operation code from the tail of the previous word. A stray serial clock pulsed while the select is high would then change the command that runs.

// File: rtl/duo_dac_pkg.sv
package duo_dac_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP    = 4'b0000,
      OP_LD_A   = 4'b0001,
      OP_LD_B   = 4'b0010,
      OP_XFER   = 4'b1000,
      OP_LDX_A  = 4'b1001,
      OP_LDX_B  = 4'b1010,
      OP_WAKE   = 4'b1101,
      OP_SLEEP  = 4'b1110,
      OP_LDX_AB = 4'b1111
   } op_e;

   typedef struct packed {
      logic ld_a;
      logic ld_b;
      logic xfer;
      logic wake;
      logic sleep;
   } act_t;

endpackage

// File: rtl/duo_dac_sync.sv
module duo_dac_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/duo_dac_serial_rx.sv
module duo_dac_serial_rx #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_i,
   input  logic              sclk_i,
   input  logic              din_i,
   output logic [WORD_W-1:0] word_o,
   output logic              load_o
);

   logic [2:0] pins_s;
   logic       csn_s, sclk_s, din_s;
   logic       csn_q, sclk_q;
   logic       shift_en;

   duo_dac_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({csn_i, sclk_i, din_i}),
      .q_o   (pins_s)
   );

   assign {csn_s, sclk_s, din_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_q  <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         csn_q  <= csn_s;
         sclk_q <= sclk_s;
      end
   end

   assign shift_en = sclk_s & ~sclk_q & ~csn_s;
   assign load_o   = csn_s & ~csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
      end else if (shift_en) begin
         word_o <= {word_o[WORD_W-2:0], din_s};
      end
   end

endmodule

// File: rtl/duo_dac_decode.sv
module duo_dac_decode
   import duo_dac_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output act_t            act_o
);

   always_comb begin
      act_o = '0;
      case (op_i)
         OP_LD_A:   act_o.ld_a = 1'b1;
         OP_LD_B:   act_o.ld_b = 1'b1;
         OP_XFER:   begin act_o.xfer = 1'b1; act_o.wake = 1'b1; end
         OP_LDX_A:  begin act_o.ld_a = 1'b1; act_o.xfer = 1'b1; act_o.wake = 1'b1; end
         OP_LDX_B:  begin act_o.ld_b = 1'b1; act_o.xfer = 1'b1; act_o.wake = 1'b1; end
         OP_WAKE:   act_o.wake = 1'b1;
         OP_SLEEP:  act_o.sleep = 1'b1;
         OP_LDX_AB: begin
            act_o.ld_a = 1'b1;
            act_o.ld_b = 1'b1;
            act_o.xfer = 1'b1;
            act_o.wake = 1'b1;
         end
         default:   act_o = '0;
      endcase
   end

endmodule

// File: rtl/duo_dac_chan.sv
module duo_dac_chan #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic              xfer_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] dac_o
);

   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] in_next;

   assign in_next = ld_i ? data_i : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_o <= '0;
      end else begin
         in_q <= in_next;
         if (xfer_i) dac_o <= in_next;
      end
   end

endmodule

// File: rtl/duo_dac_cmd_if.sv
module duo_dac_cmd_if
   import duo_dac_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_csn_i,
   input  logic              ser_clk_i,
   input  logic              ser_din_i,
   output logic [DATA_W-1:0] code_a_o,
   output logic [DATA_W-1:0] code_b_o,
   output logic              drive_en_a_o,
   output logic              drive_en_b_o
);

   localparam int WORD_W = OP_W + DATA_W + PAD_W;
   localparam int N_CH   = 2;
   localparam int DAT_LO = PAD_W;

   generate
      if (DATA_W < 1 || DATA_W > 24) begin : g_bad_data
         $error("duo_dac_cmd_if: DATA_W out of range");
      end
      if (PAD_W < 0 || PAD_W > 8) begin : g_bad_pad
         $error("duo_dac_cmd_if: PAD_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("duo_dac_cmd_if: SYNC_STAGES out of range");
      end
   endgenerate

   logic [WORD_W-1:0] cmd_word;
   logic              cmd_load;
   logic [OP_W-1:0]   cmd_op;
   logic [DATA_W-1:0] cmd_data;
   act_t              act;
   logic [N_CH-1:0]   ch_ld;
   logic [DATA_W-1:0] ch_dac [N_CH];
   logic              asleep;

   duo_dac_serial_rx #(
      .WORD_W      (WORD_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .csn_i  (ser_csn_i),
      .sclk_i (ser_clk_i),
      .din_i  (ser_din_i),
      .word_o (cmd_word),
      .load_o (cmd_load)
   );

   assign cmd_op   = cmd_word[WORD_W-1 -: OP_W];
   assign cmd_data = cmd_word[DAT_LO +: DATA_W];

   duo_dac_decode u_dec (
      .op_i  (cmd_op),
      .act_o (act)
   );

   assign ch_ld = {act.ld_b, act.ld_a} & {N_CH{cmd_load}};

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         duo_dac_chan #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_i   (ch_ld[c]),
            .xfer_i (cmd_load & act.xfer),
            .data_i (cmd_data),
            .dac_o  (ch_dac[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep <= 1'b0;
      end else if (cmd_load) begin
         if (act.sleep)     asleep <= 1'b1;
         else if (act.wake) asleep <= 1'b0;
      end
   end

   assign code_a_o     = ch_dac[0];
   assign code_b_o     = ch_dac[1];
   assign drive_en_a_o = ~asleep;
   assign drive_en_b_o = ~asleep;

endmodule

// File: rtl/duo_dac_cmd_if_chk.sv
module duo_dac_cmd_if_chk #(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_load,
   input logic [3:0]        cmd_op,
   input logic [DATA_W-1:0] code_a_o,
   input logic [DATA_W-1:0] code_b_o,
   input logic              drive_en_a_o,
   input logic              drive_en_b_o
);

   // R3: DAC outputs move only in the cycle after a command executes
   a_r3_hold_between_cmds: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_load |=> ($stable(code_a_o) && $stable(code_b_o)));

   // R3 / R10: input-only loads leave outputs and enables alone
   a_r10_input_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && (cmd_op == 4'b0001 || cmd_op == 4'b0010)) |=>
      ($stable(code_a_o) && $stable(code_b_o) && $stable(drive_en_a_o)));

   // R4: no-op and reserved codes change nothing visible
   a_r4_noop_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && (cmd_op inside {4'b0000, 4'b0011, 4'b0100, 4'b0101,
                                   4'b0110, 4'b0111, 4'b1011, 4'b1100})) |=>
      ($stable(code_a_o) && $stable(code_b_o) &&
       $stable(drive_en_a_o) && $stable(drive_en_b_o)));

   // R7: load-both leaves identical codes and enabled outputs
   a_r7_same_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && cmd_op == 4'b1111) |=>
      (code_a_o == code_b_o && drive_en_a_o && drive_en_b_o));

   // R8: wake-only enables and keeps codes
   a_r8_wake_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && cmd_op == 4'b1101) |=>
      (drive_en_a_o && drive_en_b_o && $stable(code_a_o) && $stable(code_b_o)));

   // R9: sleep drops enables and keeps codes
   a_r9_sleep_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && cmd_op == 4'b1110) |=>
      (!drive_en_a_o && !drive_en_b_o && $stable(code_a_o) && $stable(code_b_o)));

   // R5 / R6: every transfer enables the outputs
   a_r5_xfer_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && (cmd_op inside {4'b1000, 4'b1001, 4'b1010})) |=>
      (drive_en_a_o && drive_en_b_o));

endmodule

bind duo_dac_cmd_if duo_dac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_load     (cmd_load),
   .cmd_op       (cmd_op),
   .code_a_o     (code_a_o),
   .code_b_o     (code_b_o),
   .drive_en_a_o (drive_en_a_o),
   .drive_en_b_o (drive_en_b_o)
);

// File: tb/sim_duo_dac_cmd_if.sv
`timescale 1ns/1ps
module sim_duo_dac_cmd_if;

   localparam int DW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csn = 1'b1;
   logic          sclk = 1'b0;
   logic          din = 1'b0;
   logic [DW-1:0] code_a, code_b;
   logic          en_a, en_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   duo_dac_cmd_if u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .ser_csn_i    (csn),
      .ser_clk_i    (sclk),
      .ser_din_i    (din),
      .code_a_o     (code_a),
      .code_b_o     (code_b),
      .drive_en_a_o (en_a),
      .drive_en_b_o (en_b)
   );

   typedef struct {
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic          en;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   event go_ev;

   // bench model, built from the requirement list
   logic [15:0]   m_sh = '0;
   logic [DW-1:0] m_ia = '0, m_ib = '0, m_da = '0, m_db = '0;
   logic          m_aw = 1'b1;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic half();
      repeat (3) @(negedge clk);
   endtask

   task automatic model_exec();
      logic [3:0]    op;
      logic [DW-1:0] d;
      op = m_sh[15:12];
      d  = m_sh[11:2];
      case (op)
         4'b0001: m_ia = d;
         4'b0010: m_ib = d;
         4'b1000: begin m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'b1001: begin m_ia = d; m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'b1010: begin m_ib = d; m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'b1101: m_aw = 1'b1;
         4'b1110: m_aw = 1'b0;
         4'b1111: begin m_ia = d; m_ib = d; m_da = d; m_db = d; m_aw = 1'b1; end
         default: ;
      endcase
   endtask

   // driver: shift n bits (v[n-1] first) in one select window, then execute
   task automatic send_bits(input logic [31:0] v, input int n, input string req);
      exp_t e;
      csn = 1'b0;
      half();
      for (int i = n - 1; i >= 0; i--) begin
         din = v[i];
         half();
         sclk = 1'b1;
         m_sh = {m_sh[14:0], v[i]};
         half();
         sclk = 1'b0;
      end
      half();
      csn = 1'b1;
      model_exec();
      e.a = m_da; e.b = m_db; e.en = m_aw; e.req = req;
      exp_q.push_back(e);
      -> go_ev;
      repeat (12) @(negedge clk);
   endtask

   task automatic send_word(input logic [3:0] op, input logic [DW-1:0] d,
                            input logic [1:0] pad, input string req);
      send_bits({16'h0, op, d, pad}, 16, req);
   endtask

   // serial clock pulses with the select high (must be ignored)
   task automatic stray_clocks(input int n);
      din = 1'b1;
      for (int i = 0; i < n; i++) begin
         half();
         sclk = 1'b1;
         half();
         sclk = 1'b0;
      end
      din = 1'b0;
      half();
   endtask

   // monitor: pops one expectation per executed command
   initial begin
      forever begin
         @(go_ev);
         repeat (8) @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, "code_a", 32'(code_a), 32'(e.a));
            check(e.req, "code_b", 32'(code_b), 32'(e.b));
            check(e.req, "drive_en_a", 32'(en_a), 32'(e.en));
            check(e.req, "drive_en_b", 32'(en_b), 32'(e.en));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", "code_a", 32'(code_a), 32'h0);
      check("R11", "code_b", 32'(code_b), 32'h0);
      check("R11", "drive_en_a", 32'(en_a), 32'h1);
      check("R11", "drive_en_b", 32'(en_b), 32'h1);

      // R3 / R1: input-only loads leave outputs at zero
      send_word(4'b0001, 10'h2A5, 2'b11, "R3");
      send_word(4'b0010, 10'h13C, 2'b10, "R3");
      // R5: transfer both
      send_word(4'b1000, 10'h3FF, 2'b00, "R5");
      // R4: no-op and reserved codes do nothing, data not captured
      send_word(4'b0000, 10'h3FF, 2'b00, "R4");
      send_word(4'b0101, 10'h111, 2'b00, "R4");
      send_word(4'b1011, 10'h222, 2'b00, "R4");
      send_word(4'b1100, 10'h333, 2'b00, "R4");
      send_word(4'b1000, 10'h000, 2'b00, "R4");
      // R6: load one channel and transfer both
      send_word(4'b1001, 10'h001, 2'b01, "R6");
      send_word(4'b1010, 10'h3FF, 2'b00, "R6");
      // R9: sleep keeps codes, data ignored
      send_word(4'b1110, 10'h155, 2'b00, "R9");
      // R10: load in sleep without waking
      send_word(4'b0001, 10'h0AA, 2'b00, "R10");
      // R8: wake shows the old DAC codes
      send_word(4'b1101, 10'h2FF, 2'b00, "R8");
      send_word(4'b1110, 10'h000, 2'b00, "R9");
      // R10 / R5: transfer from sleep shows the new input
      send_word(4'b1000, 10'h000, 2'b00, "R10");
      // R7: same code into both channels
      send_word(4'b1111, 10'h200, 2'b00, "R7");
      // R2 / R12: a short window borrows its op code (1001) from the tail
      // of the previous word; stray clocks with the select high would corrupt it
      send_word(4'b0000, 10'b0000000010, 2'b01, "R12");
      stray_clocks(5);
      send_bits({20'h0, 10'h0C3, 2'b00}, 12, "R2");
      // R12: an over-long window uses only the last 16 bits
      send_bits({12'h0, 4'b1111, 4'b1010, 10'h111, 2'b00}, 20, "R12");
      // R1: don't-care bits do not disturb the data code
      send_word(4'b1111, 10'h0F0, 2'b11, "R1");

      repeat (20) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule